// File: doc/BRIEF.md
# Vector Lane Pack/Unpack/Replicate Unit

This unit moves single elements between a compact vector and one lane of a set of 64-bit spread registers. The compact vector is made of one or two registers. The spread side holds from the compact count up to four registers. Elements are 8, 16 or 32 bits wide, so a register holds eight, four or two lanes.

The unit has three modes. Insert mode places compact element i into the chosen lane of spread register i and keeps every other lane of that register from its prior contents. Broadcast mode fills every lane of spread register i with compact element i. Gather mode reads the chosen lane of each spread source register and lays those elements side by side in the compact destination. A request is taken on a one-cycle start pulse. The result appears one cycle later with a valid strobe, a per-register write-enable vector and an error flag.

Top module: `lsp_top`

## Requirements
- R1: While reset is held and after it is released, valid_o, err_o, we_o and data_o are all zero until the first request.
- R2: A request sampled with start_i high at a rising edge produces valid_o high for exactly the following cycle. A cycle with start_i low produces no valid_o in the next cycle.
- R3: In insert mode (mode_i=0), spread register r for r < n_spread_i equals prior register r with lane lane_i replaced by compact element r. Compact element k occupies bits [k*w +: w] of the 128-bit vector {src register 1, src register 0}.
- R4: In broadcast mode (mode_i=1), every lane of spread register r, for r < n_spread_i, equals compact element r.
- R5: In gather mode (mode_i=2), compact element k for k < n_spread_i is lane lane_i of source register k. All higher element positions of the compact result are zero. Compact register j is bits [64*j +: 64] of that result.
- R6: we_o bit r is set for r < n_spread_i in insert and broadcast modes, and for r < n_compact_i in gather mode. All other bits are clear, and the data_o word of every register whose bit is clear is zero.
- R7: esize_i encodes the element width: 0 is 8 bits (8 lanes), 1 is 16 bits (4 lanes), 2 is 32 bits (2 lanes). Lane l of a register is bits [l*w +: w].
- R8: err_o is set with valid_o, and we_o and data_o are zero, in any of these cases: lane_i is not below the lane count, esize_i=3, mode_i=3, n_compact_i is outside 1..2, n_spread_i is outside n_compact_i..4, or n_spread_i exceeds n_compact_i times the lane count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request strobe |
| mode_i | input | 2 | 0 insert, 1 broadcast, 2 gather |
| esize_i | input | 2 | Element width code |
| lane_i | input | 3 | Selected lane |
| n_compact_i | input | 2 | Compact register count |
| n_spread_i | input | 3 | Spread register count |
| src_i | input | 256 | Source registers, register r at bits [64*r +: 64] |
| prior_i | input | 256 | Prior spread contents for insert mode |
| data_o | output | 256 | Result registers |
| we_o | output | 4 | Per-register write enables |
| valid_o | output | 1 | Result strobe |
| err_o | output | 1 | Request rejected |

## Verification
A wrong lane shift or a wrong element mask shows up in the same result beat as a corrupted neighbour lane in insert mode. In broadcast mode it shows as unequal lanes, and in gather mode as misplaced compact elements, all one cycle after the start pulse. A stale or wrongly decoded count shows as extra or missing write-enable bits, or as nonzero data in registers that are not enabled. A defect in the configuration check shows as an error flag on a legal request, or as writes on an illegal one. Timing faults show as a strobe that is missing, doubled or arrives with no request.

// File: rtl/lsp_pkg.sv
package lsp_pkg;
    localparam int REG_W       = 64;
    localparam int COMPACT_MAX = 2;
    localparam int SPREAD_MAX  = 4;
    localparam int LANE_W      = $clog2(REG_W / 8);
    localparam int NC_W        = $clog2(COMPACT_MAX + 1);
    localparam int NS_W        = $clog2(SPREAD_MAX + 1);
    localparam int CW          = COMPACT_MAX * REG_W;

    typedef enum logic [1:0] {
        MODE_INSERT = 2'd0,
        MODE_BCAST  = 2'd1,
        MODE_GATHER = 2'd2
    } lsp_mode_e;

    typedef struct packed {
        logic                        valid;
        logic                        err;
        logic [SPREAD_MAX-1:0]       we;
        logic [SPREAD_MAX*REG_W-1:0] data;
    } lsp_out_t;
endpackage

// File: rtl/lsp_cfg_check.sv
module lsp_cfg_check
    import lsp_pkg::*;
(
    input  logic [1:0]        mode,
    input  logic [1:0]        esize,
    input  logic [LANE_W-1:0] lane,
    input  logic [NC_W-1:0]   n_compact,
    input  logic [NS_W-1:0]   n_spread,
    output logic              bad
);
    logic [LANE_W:0] lanes;
    logic [4:0]      cap;

    always_comb begin
        lanes = (LANE_W+1)'(REG_W / 8) >> esize;
        cap   = 5'(n_compact) * 5'(lanes);
        bad   = (esize == 2'd3) || (mode == 2'd3)
             || (n_compact == '0) || (32'(n_compact) > COMPACT_MAX)
             || (32'(n_spread) < 32'(n_compact)) || (32'(n_spread) > SPREAD_MAX)
             || ({1'b0, lane} >= lanes)
             || (5'(n_spread) > cap);
    end
endmodule

// File: rtl/lsp_extract.sv
module lsp_extract #(
    parameter int W  = 64,
    parameter int IW = 3
) (
    input  logic [W-1:0]  vec,
    input  logic [IW-1:0] idx,
    input  logic [1:0]    esize,
    output logic [31:0]   elem
);
    logic [9:0]   sh;
    logic [W-1:0] sel;
    logic [31:0]  emask;

    always_comb begin
        sh    = 10'({idx, 3'b000}) << esize;
        sel   = vec >> sh;
        emask = (esize == 2'd0) ? 32'h0000_00FF :
                (esize == 2'd1) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
        elem  = sel[31:0] & emask;
    end
endmodule

// File: rtl/lsp_merge.sv
module lsp_merge
    import lsp_pkg::*;
(
    input  logic [REG_W-1:0]  prior,
    input  logic [31:0]       elem,
    input  logic [LANE_W-1:0] lane,
    input  logic [1:0]        esize,
    input  logic              bcast,
    output logic [REG_W-1:0]  result
);
    localparam int SHW = $clog2(REG_W);
    logic [SHW-1:0]   sh;
    logic [REG_W-1:0] lmask;
    logic [REG_W-1:0] spread;

    always_comb begin
        sh    = SHW'({lane, 3'b000}) << esize;
        lmask = REG_W'((esize == 2'd0) ? 32'h0000_00FF :
                       (esize == 2'd1) ? 32'h0000_FFFF : 32'hFFFF_FFFF) << sh;
        case (esize)
            2'd0:    spread = {(REG_W/8){elem[7:0]}};
            2'd1:    spread = {(REG_W/16){elem[15:0]}};
            default: spread = {(REG_W/32){elem}};
        endcase
        if (bcast)
            result = spread;
        else
            result = (prior & ~lmask) | (REG_W'(elem) << sh);
    end
endmodule

// File: rtl/lsp_top.sv
module lsp_top
    import lsp_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start_i,
    input  logic [1:0]                  mode_i,
    input  logic [1:0]                  esize_i,
    input  logic [LANE_W-1:0]           lane_i,
    input  logic [NC_W-1:0]             n_compact_i,
    input  logic [NS_W-1:0]             n_spread_i,
    input  logic [SPREAD_MAX*REG_W-1:0] src_i,
    input  logic [SPREAD_MAX*REG_W-1:0] prior_i,
    output logic [SPREAD_MAX*REG_W-1:0] data_o,
    output logic [SPREAD_MAX-1:0]       we_o,
    output logic                        valid_o,
    output logic                        err_o
);
    lsp_out_t st_d, st_q;
    logic     bad;

    logic [31:0]      celem  [SPREAD_MAX];
    logic [31:0]      lelem  [SPREAD_MAX];
    logic [REG_W-1:0] merged [SPREAD_MAX];
    logic [CW-1:0]    gath;

    lsp_cfg_check u_cfg (
        .mode      (mode_i),
        .esize     (esize_i),
        .lane      (lane_i),
        .n_compact (n_compact_i),
        .n_spread  (n_spread_i),
        .bad       (bad)
    );

    for (genvar g = 0; g < SPREAD_MAX; g++) begin : g_reg
        lsp_extract #(.W(CW), .IW(3)) u_cel (
            .vec   (src_i[CW-1:0]),
            .idx   (3'(g)),
            .esize (esize_i),
            .elem  (celem[g])
        );
        lsp_extract #(.W(REG_W), .IW(LANE_W)) u_lel (
            .vec   (src_i[g*REG_W +: REG_W]),
            .idx   (lane_i),
            .esize (esize_i),
            .elem  (lelem[g])
        );
        lsp_merge u_mrg (
            .prior  (prior_i[g*REG_W +: REG_W]),
            .elem   (celem[g]),
            .lane   (lane_i),
            .esize  (esize_i),
            .bcast  (mode_i == MODE_BCAST),
            .result (merged[g])
        );
    end

    always_comb begin
        gath = '0;
        for (int i = 0; i < SPREAD_MAX; i++) begin
            if (i < 32'(n_spread_i))
                gath = gath | (CW'(lelem[i]) << (8'(i * 8) << esize_i));
        end

        st_d       = st_q;
        st_d.valid = 1'b0;
        st_d.err   = 1'b0;
        st_d.we    = '0;
        if (start_i) begin
            st_d.valid = 1'b1;
            st_d.err   = bad;
            st_d.data  = '0;
            if (!bad) begin
                for (int r = 0; r < SPREAD_MAX; r++) begin
                    if (mode_i == MODE_GATHER) begin
                        if (r < 32'(n_compact_i) && r < COMPACT_MAX) begin
                            st_d.we[r] = 1'b1;
                            st_d.data[r*REG_W +: REG_W] = gath[(r % COMPACT_MAX)*REG_W +: REG_W];
                        end
                    end else if (r < 32'(n_spread_i)) begin
                        st_d.we[r] = 1'b1;
                        st_d.data[r*REG_W +: REG_W] = merged[r];
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign data_o  = st_q.data;
    assign we_o    = st_q.we;
    assign valid_o = st_q.valid;
    assign err_o   = st_q.err;

    AST_START_GIVES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> valid_o); // R2
    AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> !valid_o); // R2
    AST_LANE_RANGE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && esize_i == 2'd2 && lane_i >= 3'd2) |=> (err_o && we_o == '0)); // R8
    AST_GATHER_UPPER_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && mode_i == MODE_GATHER) |=> (we_o[SPREAD_MAX-1:COMPACT_MAX] == '0)); // R6
    AST_BCAST_BYTES_EQ: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !bad && mode_i == MODE_BCAST && esize_i == 2'd0)
        |=> (data_o[7:0] == data_o[15:8] && data_o[7:0] == data_o[63:56])); // R4
endmodule

// File: tb/tb_lsp_top.sv
module tb_lsp_top;
    import lsp_pkg::*;

    localparam int CLK_PERIOD = 10;

    typedef struct {
        lsp_out_t exp;
        string    tag;
    } item_t;

    logic                        clk = 1'b0;
    logic                        rst_n = 1'b0;
    logic                        start_i = 1'b0;
    logic [1:0]                  mode_i = '0;
    logic [1:0]                  esize_i = '0;
    logic [LANE_W-1:0]           lane_i = '0;
    logic [NC_W-1:0]             n_compact_i = '0;
    logic [NS_W-1:0]             n_spread_i = '0;
    logic [SPREAD_MAX*REG_W-1:0] src_i = '0;
    logic [SPREAD_MAX*REG_W-1:0] prior_i = '0;
    logic [SPREAD_MAX*REG_W-1:0] data_o;
    logic [SPREAD_MAX-1:0]       we_o;
    logic                        valid_o;
    logic                        err_o;

    int    n_checks = 0;
    int    n_fail = 0;
    bit    done = 1'b0;
    item_t sb[$];

    lsp_top dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic lsp_out_t model(int md, int es, int ln, int nc, int ns,
                                       logic [255:0] s, logic [255:0] p);
        lsp_out_t o;
        int lanes, w;
        logic [127:0] cv;
        o = '0;
        o.valid = 1'b1;
        lanes = (es < 3) ? (8 >> es) : 0;
        w = 8 << es;
        if (es == 3 || md == 3 || nc < 1 || nc > 2 || ns < nc || ns > 4 ||
            ln >= lanes || ns > nc * lanes) begin
            o.err = 1'b1;
            return o;
        end
        cv = s[127:0];
        if (md == 2) begin
            cv = '0;
            for (int r = 0; r < ns; r++)
                for (int b = 0; b < w; b++)
                    cv[r*w + b] = s[r*64 + ln*w + b];
            for (int r = 0; r < nc; r++) begin
                o.we[r] = 1'b1;
                for (int b = 0; b < 64; b++) o.data[r*64 + b] = cv[r*64 + b];
            end
        end else begin
            for (int r = 0; r < ns; r++) begin
                o.we[r] = 1'b1;
                if (md == 0) begin
                    for (int b = 0; b < 64; b++) o.data[r*64 + b] = p[r*64 + b];
                    for (int b = 0; b < w; b++) o.data[r*64 + ln*w + b] = cv[r*w + b];
                end else begin
                    for (int l = 0; l < lanes; l++)
                        for (int b = 0; b < w; b++) o.data[r*64 + l*w + b] = cv[r*w + b];
                end
            end
        end
        return o;
    endfunction

    task automatic send(int md, int es, int ln, int nc, int ns,
                        logic [255:0] s, logic [255:0] p, string tag);
        item_t it;
        @(posedge clk);
        #2;
        mode_i = 2'(md); esize_i = 2'(es); lane_i = 3'(ln);
        n_compact_i = 2'(nc); n_spread_i = 3'(ns);
        src_i = s; prior_i = p; start_i = 1'b1;
        it.exp = model(md, es, ln, nc, ns, s, p);
        it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic idle(int n);
        @(posedge clk);
        #2;
        start_i = 1'b0;
        repeat (n) @(posedge clk);
    endtask

    function automatic logic [255:0] rnd256();
        return {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
    endfunction

    always @(negedge clk) begin
        if (rst_n && !done && valid_o) begin
            n_checks++;
            if (sb.size() == 0) begin
                n_fail++;
                $display("FAIL R2: unexpected valid strobe, actual valid=%0b expected valid=0", valid_o);
            end else begin
                item_t it;
                it = sb.pop_front();
                if (err_o !== it.exp.err || we_o !== it.exp.we || data_o !== it.exp.data) begin
                    n_fail++;
                    $display("FAIL %s: actual err=%0b we=%h data=%h expected err=%0b we=%h data=%h",
                             it.tag, err_o, we_o, data_o, it.exp.err, it.exp.we, it.exp.data);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [255:0] s, p;
        s = {64'hF0E1D2C3B4A59687, 64'h0123456789ABCDEF, 64'h1122334455667788, 64'h8877665544332211};
        p = {64'hAAAAAAAAAAAAAAAA, 64'hBBBBBBBBBBBBBBBB, 64'hCCCCCCCCCCCCCCCC, 64'hDDDDDDDDDDDDDDDD};
        repeat (3) @(posedge clk);
        @(negedge clk);
        n_checks++;
        if (valid_o !== 1'b0 || err_o !== 1'b0 || we_o !== '0 || data_o !== '0) begin
            n_fail++;
            $display("FAIL R1: actual valid=%0b err=%0b we=%h expected all zero", valid_o, err_o, we_o);
        end
        rst_n = 1'b1;
        @(negedge clk);
        n_checks++;
        if (valid_o !== 1'b0 || we_o !== '0 || data_o !== '0) begin
            n_fail++;
            $display("FAIL R1: after release actual valid=%0b we=%h expected zero", valid_o, we_o);
        end

        send(0, 0, 3, 1, 4, s, p, "R3/R6/R7 insert 8b");
        send(0, 1, 2, 2, 3, s, p, "R3/R6/R7 insert 16b");
        send(0, 2, 1, 2, 4, s, p, "R3/R6/R7 insert 32b");
        idle(2);
        send(1, 0, 0, 1, 2, s, p, "R4/R6 bcast 8b");
        send(1, 2, 1, 2, 4, s, p, "R4/R6 bcast 32b");
        send(1, 1, 3, 1, 1, s, p, "R4/R6 bcast 16b");
        idle(1);
        send(2, 0, 7, 1, 4, s, p, "R5/R6 gather 8b");
        send(2, 1, 0, 2, 2, s, p, "R5/R6 gather 16b");
        send(2, 2, 1, 2, 3, s, p, "R5/R6 gather 32b");
        idle(3);
        send(0, 2, 2, 1, 2, s, p, "R8 lane range");
        send(1, 3, 0, 1, 1, s, p, "R8 esize code");
        send(3, 0, 0, 1, 1, s, p, "R8 mode code");
        send(0, 2, 0, 1, 4, s, p, "R8 capacity");
        send(2, 0, 0, 2, 1, s, p, "R8 spread below compact");
        send(2, 0, 0, 0, 1, s, p, "R8 compact zero");
        idle(2);
        for (int k = 0; k < 40; k++) begin
            send($urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 7),
                 $urandom_range(0, 2), $urandom_range(1, 4), rnd256(), rnd256(),
                 "R3/R4/R5/R8 random");
            if (k % 7 == 0) idle(1);
        end
        idle(6);
        @(negedge clk);
        n_checks++;
        if (sb.size() != 0) begin
            n_fail++;
            $display("FAIL R2: missing strobes actual pending=%0d expected 0", sb.size());
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule